// File: doc/BRIEF.md
# Multi-Output Programmable Clock Prescaler

This block turns one peripheral clock into four count-enable ticks that any number of timer channels can share. Each tick is a synchronous enable one clock cycle wide, not a derived clock, so every consumer stays in the single clock domain. Outputs 0, 1 and 2 each fire once every 2^k cycles, with k chosen per output from 0 to 15. Output 3 has a power-of-two stage of its own followed by a modulus divider, which gives rates that are not powers of two.

All power-of-two stages tap one shared free-running 16-bit counter, so outputs with related settings stay phase-aligned. A global enable starts the counter from zero and, when it is low, holds everything idle. Setting changes never cut a division period short. The output keeps its old setting until its current period ends and only then takes up the new one.

Top module: `tick_prescaler`

## Requirements
- R1: While rst_n is low, all four bits of tick_en are 0. After reset is released with en low, no tick appears.
- R2: While en is low, no tick is produced and the shared counter is held at zero. After en rises, cycles are counted afresh: the n-th rising edge with en high is enabled edge n, and a tick caused by that edge is seen in the cycle that follows it.
- R3: An exponent of 0 on any output gives a tick after every enabled edge.
- R4: For outputs 0 to 2 with a fixed exponent k (pow_sel0..2, unsigned, 0 to 15), ticks follow enabled edges 2^k, 2·2^k, 3·2^k and so on. Each output is independent of the others' settings.
- R5: Every tick is one clock cycle wide. An output with exponent 1 or more never holds its tick high on two cycles in a row.
- R6: Output 3 ticks once every 2^k3·N enabled edges. k3 is pow_sel3, and N is frac_div read as an unsigned value from 1 to 255, with 0 standing for 256. The first tick follows enabled edge 2^k3·N.
- R7: A new exponent on outputs 0 to 2 takes effect only at the end of the period in progress. After a decrease, the following ticks are spaced 2^new at once. After an increase, the next tick falls where the low `new` bits of the shared counter next roll over.
- R8: A change of pow_sel3 or frac_div takes effect only after output 3's whole current period (2^k3·N edges) ends.
- R9: With steady settings, two outputs with exponents j ≤ k are aligned: every tick of the output with exponent k coincides with a tick of the output with exponent j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Global enable; low holds the counters at zero |
| pow_sel0 | input | 4 | Exponent for output 0 |
| pow_sel1 | input | 4 | Exponent for output 1 |
| pow_sel2 | input | 4 | Exponent for output 2 |
| pow_sel3 | input | 4 | Exponent of output 3's power-of-two stage |
| frac_div | input | 8 | Modulus N of output 3 (0 means 256) |
| tick_en | output | 4 | One-cycle count-enable pulses, bit i for output i |

## Verification
Every result is due one register after its cause. The shared counter and the per-output state update on enabled edge n, and the tick that edge produces is visible in the following cycle. Output 0 with exponent 3 is therefore first seen high just after enabled edge 8. The bench counts enabled edges itself. After each rising edge it samples tick_en at the falling edge and records the edge index of every pulse, then compares those indices with the 2^k and 2^k·N positions the requirements give. Setting changes are driven at a falling edge, so the next rising edge is the first to see them, and the expected positions of the old-period and new-period ticks are worked out from that edge.

// File: rtl/prescaler_pkg.sv
// Shared widths and types for the tick prescaler.
// Assumes: base counter width is a power of two wide enough for the largest exponent.
package prescaler_pkg;
    localparam int CNT_W     = 16;              // shared counter width
    localparam int EXP_W     = $clog2(CNT_W);   // exponent field width (0..CNT_W-1)
    localparam int DIV_W     = 8;               // modulus field width for output 3
    localparam int NUM_TICKS = 4;               // number of tick outputs
    localparam int NUM_POW   = NUM_TICKS - 1;   // outputs that are pure power-of-two

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [EXP_W-1:0] exp_t;
    typedef logic [DIV_W-1:0] div_t;
endpackage

// File: rtl/prescaler_base_cnt.sv
// Free-running shared counter that every power-of-two stage taps.
// Assumes: en low means idle; counting always restarts from zero.
module prescaler_base_cnt
    import prescaler_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output cnt_t cnt
);

    // Advance by one per enabled cycle, hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/prescaler_pow2_tap.sv
// Power-of-two tap: flags the cycle in which the low k bits of the shared
// counter are all ones (they roll over to zero on the next edge).
// The exponent in use is re-latched only at period_end, or while idle, so a
// change never shortens the period in progress.
// Assumes: period_end comes from the owner and marks the end of a full period.
module prescaler_pow2_tap
    import prescaler_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  exp_t exp_req,
    input  cnt_t cnt,
    input  logic period_end,
    output logic hit
);

    exp_t exp_act;
    cnt_t low_mask;

    // Latch the requested exponent while idle or when a period closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_act <= '0;
        end else if (!en || period_end) begin
            exp_act <= exp_req;
        end
    end

    // Build a mask of the low exp_act bits.
    always_comb begin
        for (int b = 0; b < CNT_W; b++) begin
            low_mask[b] = (b < int'(exp_act));
        end
    end

    // Rollover detect on the masked counter bits.
    always_comb begin
        hit = en && ((cnt & low_mask) == low_mask);
    end

endmodule

// File: rtl/prescaler_mod_stage.sv
// Modulus divider for output 3: counts power-of-two hits and closes a
// period on every N-th one; N = 0 stands for 2^DIV_W.
// Assumes: hit is already gated by en.
module prescaler_mod_stage
    import prescaler_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hit,
    input  div_t div_req,
    output logic period_end
);

    div_t hit_cnt;
    div_t n_act;
    div_t last_idx;

    // Index of the final hit in a period; 0 - 1 wraps to give N = 256.
    always_comb begin
        last_idx   = n_act - DIV_W'(1);
        period_end = hit && (hit_cnt == last_idx);
    end

    // Count hits; reload modulus when idle or at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_cnt <= '0;
            n_act   <= '0;
        end else if (!en || period_end) begin
            hit_cnt <= '0;
            n_act   <= div_req;
        end else if (hit) begin
            hit_cnt <= hit_cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/tick_prescaler.sv
// Four-output count-enable prescaler. Outputs 0..NUM_POW-1 are power-of-two
// divisions of clk; the last output cascades a modulus stage behind its own
// power-of-two tap. All outputs are registered one-cycle pulses.
// Assumes: a single clock domain; consumers use tick_en as clock enables.
module tick_prescaler
    import prescaler_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [EXP_W-1:0]     pow_sel0,
    input  logic [EXP_W-1:0]     pow_sel1,
    input  logic [EXP_W-1:0]     pow_sel2,
    input  logic [EXP_W-1:0]     pow_sel3,
    input  logic [DIV_W-1:0]     frac_div,
    output logic [NUM_TICKS-1:0] tick_en
);

    cnt_t                 base_cnt;
    exp_t                 sel_vec [NUM_TICKS];
    logic [NUM_TICKS-1:0] hit;
    logic [NUM_TICKS-1:0] period_end;

    // Gather the exponent fields into an indexable array.
    always_comb begin
        sel_vec[0] = pow_sel0;
        sel_vec[1] = pow_sel1;
        sel_vec[2] = pow_sel2;
        sel_vec[3] = pow_sel3;
    end

    prescaler_base_cnt i_base (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .cnt   (base_cnt)
    );

    for (genvar g = 0; g < NUM_TICKS; g++) begin : g_out
        prescaler_pow2_tap i_tap (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (en),
            .exp_req    (sel_vec[g]),
            .cnt        (base_cnt),
            .period_end (period_end[g]),
            .hit        (hit[g])
        );

        if (g < NUM_POW) begin : g_plain
            assign period_end[g] = hit[g];
        end else begin : g_frac
            prescaler_mod_stage i_mod (
                .clk        (clk),
                .rst_n      (rst_n),
                .en         (en),
                .hit        (hit[g]),
                .div_req    (frac_div),
                .period_end (period_end[g])
            );
        end
    end

    // Register the period ends as one-cycle enables.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            tick_en <= '0;
        end else begin
            tick_en <= period_end;
        end
    end

endmodule

// File: rtl/tick_prescaler_chk.sv
// Property checker for tick_prescaler, attached by bind below.
// Assumes: read-only view of ports plus the shared counter and output-3 tap.
module tick_prescaler_chk
    import prescaler_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic [NUM_TICKS-1:0] tick,
    input cnt_t                 cnt,
    input logic                 hit3
);

    logic [DIV_W:0] hits_in_period;

    // Count output-3 tap hits belonging to the period now running.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hits_in_period <= '0;
        end else if (tick[NUM_TICKS-1]) begin
            hits_in_period <= (DIV_W+1)'(hit3);
        end else if (hit3) begin
            hits_in_period <= hits_in_period + (DIV_W+1)'(1);
        end
    end

    // R2
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tick == '0) && (cnt == '0));

    // R4
    base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> cnt == $past(cnt) + CNT_W'(1));

    // R6
    out3_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick[NUM_TICKS-1] |-> $past(hit3));

    // R6
    out3_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick[NUM_TICKS-1] |-> (hits_in_period >= 1) && (hits_in_period <= (1 << DIV_W)));

endmodule

bind tick_prescaler tick_prescaler_chk i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .tick  (tick_en),
    .cnt   (base_cnt),
    .hit3  (hit[3])
);

// File: tb/test_tick_prescaler.sv
`timescale 1ns/1ps
module test_tick_prescaler;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic [3:0] pow_sel0, pow_sel1, pow_sel2, pow_sel3;
    logic [7:0] frac_div;
    logic [3:0] tick_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc;
    int hist [4][8];
    int hcnt [4];
    int misalign;
    int double_hi;
    logic [3:0] prev_tick;

    always #5 clk = ~clk;

    tick_prescaler i_tick_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .pow_sel0 (pow_sel0),
        .pow_sel1 (pow_sel1),
        .pow_sel2 (pow_sel2),
        .pow_sel3 (pow_sel3),
        .frac_div (frac_div),
        .tick_en  (tick_en)
    );

    task automatic check(input string req, input int act, input int expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic clear_log();
        cyc = 0; misalign = 0; double_hi = 0; prev_tick = '0;
        for (int i = 0; i < 4; i++) begin
            hcnt[i] = 0;
            for (int j = 0; j < 8; j++) hist[i][j] = 0;
        end
    endtask

    // Advance n edges, logging tick positions by enabled-edge index.
    task automatic step(input int n);
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (tick_en[i]) begin
                    if (hcnt[i] < 8) hist[i][hcnt[i]] = cyc;
                    hcnt[i]++;
                end
            end
            if (tick_en[1] && !tick_en[0]) misalign++;
            for (int i = 1; i < 4; i++) if (tick_en[i] && prev_tick[i]) double_hi++;
            prev_tick = tick_en;
        end
    endtask

    // Idle for one edge with the given settings, then enable and reset the log.
    task automatic start(input int s0, input int s1, input int s2, input int s3, input int d);
        en = 1'b0;
        pow_sel0 = 4'(s0); pow_sel1 = 4'(s1); pow_sel2 = 4'(s2); pow_sel3 = 4'(s3);
        frac_div = 8'(d);
        @(posedge clk); @(negedge clk);
        en = 1'b1;
        clear_log();
    endtask

    task automatic t_reset();
        check("R1 ticks low in reset", int'(tick_en), 0);
        @(negedge clk); rst_n = 1'b1;
        clear_log();
        step(20);
        check("R1 no tick after reset, en low", hcnt[0] + hcnt[1] + hcnt[2] + hcnt[3], 0);
    endtask

    task automatic t_zero_exp();
        start(0, 0, 0, 0, 1);
        step(10);
        check("R3 out0 every cycle", hcnt[0], 10);
        check("R3 out2 every cycle", hcnt[2], 10);
        check("R3 first tick at edge 1", hist[1][0], 1);
        check("R6 out3 k=0 N=1 every cycle", hcnt[3], 10);
    endtask

    task automatic t_pow2();
        start(1, 3, 5, 0, 0);
        step(256);
        check("R4 out0 first", hist[0][0], 2);
        check("R4 out0 second", hist[0][1], 4);
        check("R5 out0 k=1 count", hcnt[0], 128);
        check("R4 out1 first", hist[1][0], 8);
        check("R4 out1 second", hist[1][1], 16);
        check("R4 out2 first", hist[2][0], 32);
        check("R4 out2 count", hcnt[2], 8);
        check("R6 out3 N=256 first", hist[3][0], 256);
        check("R5 no double-wide ticks", double_hi, 0);
    endtask

    task automatic t_max();
        start(15, 14, 0, 0, 1);
        step(32768);
        check("R4 out0 k=15 first", hist[0][0], 32768);
        check("R4 out0 k=15 count", hcnt[0], 1);
        check("R4 out1 k=14 second", hist[1][1], 32768);
    endtask

    task automatic t_out3();
        start(0, 0, 0, 2, 3);
        step(30);
        check("R6 out3 k=2 N=3 first", hist[3][0], 12);
        check("R6 out3 k=2 N=3 second", hist[3][1], 24);
        check("R6 out3 k=2 N=3 count", hcnt[3], 2);
        start(0, 0, 0, 4, 1);
        step(40);
        check("R6 out3 k=4 N=1 first", hist[3][0], 16);
        check("R6 out3 k=4 N=1 second", hist[3][1], 32);
    endtask

    task automatic t_align();
        start(2, 4, 0, 0, 1);
        step(64);
        check("R9 out1 ticks on out0 ticks", misalign, 0);
        check("R9 out1 count", hcnt[1], 4);
    endtask

    task automatic t_change_down();
        start(4, 0, 0, 0, 1);
        step(5);
        pow_sel0 = 4'd2;
        step(20);
        check("R7 decrease old period kept", hist[0][0], 16);
        check("R7 decrease new spacing a", hist[0][1], 20);
        check("R7 decrease new spacing b", hist[0][2], 24);
    endtask

    task automatic t_change_up();
        start(2, 0, 0, 0, 1);
        step(5);
        pow_sel0 = 4'd4;
        step(28);
        check("R7 increase first", hist[0][0], 4);
        check("R7 increase old period kept", hist[0][1], 8);
        check("R7 increase next rollover", hist[0][2], 16);
        check("R7 increase steady", hist[0][3], 32);
    endtask

    task automatic t_change3();
        start(0, 0, 0, 0, 5);
        step(2);
        frac_div = 8'd2;
        step(8);
        check("R8 out3 old period kept", hist[3][0], 5);
        check("R8 out3 new modulus a", hist[3][1], 7);
        check("R8 out3 new modulus b", hist[3][2], 9);
    endtask

    task automatic t_disable();
        start(2, 0, 0, 0, 1);
        step(10);
        check("R2 running before disable", hcnt[0], 2);
        en = 1'b0;
        clear_log();
        step(5);
        check("R2 no tick while disabled", hcnt[0] + hcnt[3], 0);
        en = 1'b1;
        clear_log();
        step(4);
        check("R2 restart from zero phase", hist[0][0], 4);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0;
        pow_sel0 = '0; pow_sel1 = '0; pow_sel2 = '0; pow_sel3 = '0; frac_div = 8'd1;
        clear_log();
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_zero_exp();
        t_pow2();
        t_max();
        t_out3();
        t_align();
        t_change_down();
        t_change_up();
        t_change3();
        t_disable();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule